// File: doc/BRIEF.md
# Identification Page Write and Lock Controller

This block sits behind a byte-level two-wire serial slave front end. The front end reports start and stop conditions and hands over each received byte with a one-cycle strobe. The block recognises write transactions that carry the identification select code and decodes the two address bytes. It returns an acknowledge decision for every byte it is shown. It serves two commands that share one select code, and one address bit tells them apart.

The first command fills a 64-byte identification page. Each data byte is held in a page buffer at a running offset that wraps from 63 back to 0. At the closing stop condition the buffered bytes are replayed as write requests into a 64x8 identification store, one per cycle. The second command sets a lock flag. The flag behaves as non-volatile: the synchronous reset leaves it alone, and only a separate power-on initialisation input clears it. Once the flag is set, data bytes of either command get no acknowledge and the store receives no further writes.

Top module: `idpage_ctl`

## Requirements
- R1: A select byte is acknowledged only when bits 7:4 equal 1011, bits 3:1 equal the DEV_SEL parameter (default 000) and bit 0 is 0. Any other select byte, and every later byte of that transaction, gets no acknowledge and causes no store write.
- R2: Once the select byte matches, the select byte and both address bytes are acknowledged whatever the lock state.
- R3: For every byte strobe, ack_vld is high for exactly one cycle, in the cycle that follows the strobe. ack carries the decision in that cycle.
- R4: In a page write, bit 2 of the first address byte is 0 and its other bits are ignored. The first data byte goes to the offset given by bits 5:0 of the second address byte. Each later byte goes to the next offset, and 63 wraps to 0. While unlocked, every data byte is acknowledged.
- R5: A stop condition after at least one data byte of a page write starts a burst of write requests. The burst begins in the cycle after the stop, with one request per cycle and consecutive addresses, starting at the first offset. If more than 64 bytes arrived, the burst holds 64 requests and each one carries the latest byte for its offset.
- R6: A page write closed by a repeated start, or closed by a stop before any data byte, produces no store write.
- R7: In a lock command, bit 2 of the first address byte is 1. The first data byte is acknowledged while unlocked. If that byte has bit 1 set, locked rises in the cycle after the closing stop. If bit 1 is clear, the lock does not change. Further data bytes in the same command are not acknowledged.
- R8: While locked, data bytes of either command are not acknowledged, and no write request is issued.
- R9: rst returns the transaction logic to idle and keeps locked. por clears locked.
- R10: A lock command closed by a repeated start instead of a stop leaves the lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the transaction logic |
| por | input | 1 | Power-on initialisation, also clears the lock |
| start_i | input | 1 | Start or repeated start seen by the front end |
| stop_i | input | 1 | Stop condition seen by the front end |
| byte_vld | input | 1 | Received byte strobe |
| byte_dat | input | 8 | Received byte |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| wr_en | output | 1 | Store write request |
| wr_addr | output | 6 | Store write offset |
| wr_data | output | 8 | Store write data |
| locked | output | 1 | Page lock flag |

## Verification
The assertions assume a well-behaved front end. It never raises start_i, stop_i and byte_vld in the same cycle. It always closes a byte before signalling a condition. It sends nothing while a write burst is draining. The stimulus keeps to these rules: every event is a single-cycle pulse driven on the falling edge, and each stop is followed by more idle cycles than the longest burst. Under these rules the write-address progression, the stickiness of the lock across rst and the absence of writes while locked can be checked on every cycle.

// File: rtl/idpage_ctl.sv
module idpage_ctl #(
  parameter logic [2:0] DEV_SEL = 3'b000,
  parameter int PAGE_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               por,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_vld,
  input  logic [7:0]         byte_dat,
  output logic               ack_vld,
  output logic               ack,
  output logic               wr_en,
  output logic [PAGE_AW-1:0] wr_addr,
  output logic [7:0]         wr_data,
  output logic               locked
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int CW = PAGE_AW + 1;
  localparam logic [3:0] DEV_TYPE = 4'b1011;
  localparam int MODE_BIT = 2;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_AH, S_AL, S_DATA, S_IGN, S_FLUSH} st_t;

  st_t st;
  logic mode, lk_seen, pend;
  logic [PAGE_AW-1:0] base, off, idx;
  logic [CW-1:0] cnt;
  logic [7:0] pbuf [PAGE];

  wire sel_ok = byte_dat[7:4] == DEV_TYPE && byte_dat[3:1] == DEV_SEL && !byte_dat[0];
  wire data_ack = !locked && (!mode || !lk_seen);
  wire buf_we = byte_vld && st == S_DATA && !locked && !mode;

  assign wr_en = st == S_FLUSH;
  assign wr_addr = base + idx;
  assign wr_data = pbuf[wr_addr];

  always_ff @(posedge clk)
    if (buf_we) pbuf[off] <= byte_dat;

  always_ff @(posedge clk) begin
    if (por) locked <= 1'b0;
    else if (!rst && stop_i && st == S_DATA && mode && pend) locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      st <= S_IDLE;
      ack_vld <= 1'b0;
      ack <= 1'b0;
      mode <= 1'b0;
      lk_seen <= 1'b0;
      pend <= 1'b0;
      base <= '0;
      off <= '0;
      idx <= '0;
      cnt <= '0;
    end else begin
      ack_vld <= byte_vld;
      ack <= 1'b0;
      if (st == S_FLUSH) begin
        idx <= idx + 1'b1;
        if ({1'b0, idx} == cnt - 1'b1) st <= S_IDLE;
      end else if (start_i) begin
        st <= S_SEL;
        cnt <= '0;
        lk_seen <= 1'b0;
        pend <= 1'b0;
      end else if (stop_i) begin
        if (st == S_DATA && !mode && cnt != '0) begin
          st <= S_FLUSH;
          idx <= '0;
        end else begin
          st <= S_IDLE;
        end
      end else if (byte_vld) begin
        case (st)
          S_SEL: begin
            ack <= sel_ok;
            st <= sel_ok ? S_AH : S_IGN;
          end
          S_AH: begin
            ack <= 1'b1;
            mode <= byte_dat[MODE_BIT];
            st <= S_AL;
          end
          S_AL: begin
            ack <= 1'b1;
            base <= byte_dat[PAGE_AW-1:0];
            off <= byte_dat[PAGE_AW-1:0];
            st <= S_DATA;
          end
          S_DATA: begin
            ack <= data_ack;
            if (!locked && !mode) begin
              off <= off + 1'b1;
              if (cnt != CW'(PAGE)) cnt <= cnt + 1'b1;
            end
            if (!locked && mode && !lk_seen) begin
              lk_seen <= 1'b1;
              pend <= byte_dat[1];
            end
          end
          default: ack <= 1'b0;
        endcase
      end
    end
  end
endmodule

module idpage_ctl_chk #(parameter int PAGE_AW = 6) (
  input logic               clk,
  input logic               rst,
  input logic               por,
  input logic               stop_i,
  input logic               byte_vld,
  input logic               ack_vld,
  input logic               ack,
  input logic               wr_en,
  input logic [PAGE_AW-1:0] wr_addr,
  input logic               locked
);
  a_r3_ack_after_byte: assert property (@(posedge clk) disable iff (rst || por)
    byte_vld |=> ack_vld);
  a_r3_no_stray_ack: assert property (@(posedge clk) disable iff (rst || por)
    ack_vld |-> $past(byte_vld));
  a_r3_ack_only_valid: assert property (@(posedge clk) disable iff (rst || por)
    ack |-> ack_vld);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst || por)
    wr_en && $past(wr_en) |-> wr_addr == PAGE_AW'($past(wr_addr) + 1'b1));
  a_r7_lock_at_stop: assert property (@(posedge clk) disable iff (rst || por)
    $rose(locked) |-> $past(stop_i));
  a_r8_no_write_locked: assert property (@(posedge clk) disable iff (rst || por)
    locked |-> !wr_en);
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (por)
    locked |=> locked);
endmodule

bind idpage_ctl idpage_ctl_chk #(.PAGE_AW(PAGE_AW)) u_chk (
  .clk(clk), .rst(rst), .por(por), .stop_i(stop_i), .byte_vld(byte_vld),
  .ack_vld(ack_vld), .ack(ack), .wr_en(wr_en), .wr_addr(wr_addr), .locked(locked)
);

// File: tb/idpage_ctl_bench.sv
`timescale 1ns/1ps
module idpage_ctl_bench;
  logic clk = 0, rst = 1, por = 1;
  logic start_i = 0, stop_i = 0, byte_vld = 0;
  logic [7:0] byte_dat = 0;
  logic ack_vld, ack, wr_en, locked;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  idpage_ctl u_idpage_ctl (
    .clk(clk), .rst(rst), .por(por), .start_i(start_i), .stop_i(stop_i),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .ack_vld(ack_vld), .ack(ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .locked(locked));

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R9";

  // behavioural model: phase 0 idle,1 sel,2 addr hi,3 addr lo,4 data,5 ignore
  int ph = 0, m_mode = 0, m_off = 0, m_base = 0, m_cnt = 0, m_seen = 0, m_pend = 0;
  int m_locked = 0, e_ackv = 0, e_ack = 0;
  int pb [64];
  int wq [$];

  always @(posedge clk) begin
    e_ackv = byte_vld && !rst && !por;
    e_ack = 0;
    if (por) m_locked = 0;
    if (rst || por) begin
      ph = 0; wq.delete(); e_ackv = 0;
    end else if (wq.size() > 0) begin
      void'(wq.pop_front());
    end else if (start_i) begin
      ph = 1; m_cnt = 0; m_seen = 0; m_pend = 0;
    end else if (stop_i) begin
      if (ph == 4 && m_mode == 0)
        for (int i = 0; i < m_cnt; i++) wq.push_back(((m_base + i) % 64) * 256 + pb[(m_base + i) % 64]);
      if (ph == 4 && m_mode == 1 && m_pend && !m_locked) m_locked = 1;
      ph = 0;
    end else if (byte_vld) begin
      if (ph == 1) begin
        e_ack = (byte_dat == 8'hB0);
        ph = e_ack ? 2 : 5;
      end else if (ph == 2) begin
        e_ack = 1; m_mode = (byte_dat >> 2) & 1; ph = 3;
      end else if (ph == 3) begin
        e_ack = 1; m_off = byte_dat % 64; m_base = m_off; ph = 4;
      end else if (ph == 4 && !m_locked) begin
        if (m_mode == 0) begin
          e_ack = 1; pb[m_off] = byte_dat; m_off = (m_off + 1) % 64;
          if (m_cnt < 64) m_cnt++;
        end else if (!m_seen) begin
          e_ack = 1; m_seen = 1; m_pend = (byte_dat >> 1) & 1;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && !por) begin
      chk("ack_vld", ack_vld, e_ackv);
      if (e_ackv) chk("ack", ack, e_ack);
      chk("wr_en", wr_en, wq.size() > 0);
      if (wq.size() > 0 && wr_en) begin
        chk("wr_addr", wr_addr, wq[0] / 256);
        chk("wr_data", wr_data, wq[0] % 256);
      end
      chk("locked", locked, m_locked);
    end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start();
    @(negedge clk) start_i = 1; @(negedge clk) start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_i = 1; @(negedge clk) stop_i = 0; idle(70);
  endtask
  task automatic send(input logic [7:0] d);
    @(negedge clk) begin byte_vld = 1; byte_dat = d; end
    @(negedge clk) byte_vld = 0;
  endtask
  task automatic hdr(input logic [7:0] sel, input logic [7:0] ah, input logic [7:0] al);
    pulse_start(); send(sel); send(ah); send(al);
  endtask

  initial begin
    idle(3); @(negedge clk) begin rst = 0; por = 0; end
    tag = "R9"; idle(3);
    chk("reset locked", locked, 0);
    chk("reset wr_en", wr_en, 0);

    tag = "R1"; hdr(8'hA0, 8'h00, 8'h00); send(8'h11); pulse_stop();
    hdr(8'hB1, 8'h00, 8'h00); pulse_stop();
    hdr(8'hB2, 8'h00, 8'h00); send(8'h22); pulse_stop();

    tag = "R4"; hdr(8'hB0, 8'h00, 8'h3E);
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
    tag = "R5"; pulse_stop();

    tag = "R4"; hdr(8'hB0, 8'hFB, 8'hC7); send(8'h5A); send(8'h5B); pulse_stop();

    tag = "R5"; hdr(8'hB0, 8'h00, 8'h05);
    for (int i = 0; i < 70; i++) send(8'(i + 16));
    pulse_stop();

    tag = "R6"; hdr(8'hB0, 8'h00, 8'h10); send(8'h77); send(8'h78); pulse_start(); idle(5);
    hdr(8'hB0, 8'h00, 8'h10); pulse_stop();

    tag = "R7"; hdr(8'hB0, 8'h04, 8'h00); send(8'hFD); pulse_stop();
    tag = "R10"; hdr(8'hB0, 8'h04, 8'h00); send(8'h02); pulse_start(); idle(5);
    tag = "R7"; hdr(8'hB0, 8'hFC, 8'h3F); send(8'h02); send(8'h02); pulse_stop();
    chk("locked after lock", locked, 1);

    tag = "R8"; hdr(8'hB0, 8'h00, 8'h00); send(8'h99); send(8'h98); pulse_stop();
    hdr(8'hB0, 8'h04, 8'h00); send(8'h02); pulse_stop();
    tag = "R2"; hdr(8'hB0, 8'h00, 8'h01); pulse_stop();

    tag = "R9"; @(negedge clk) rst = 1; @(negedge clk) rst = 0; idle(2);
    chk("lock kept over rst", locked, 1);
    @(negedge clk) por = 1; @(negedge clk) por = 0; idle(2);
    chk("lock cleared by por", locked, 0);
    hdr(8'hB0, 8'h00, 8'h20); send(8'h44); pulse_stop();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule